// File: doc/BRIEF.md
# Transparent March Self-Test Controller

This block tests a small word-addressed RAM in place, leaving the RAM with the same contents it held before the test. It runs a six-element march algorithm of the March C family in transparent form. The fixed background patterns are replaced by each cell's own original word. Where the base algorithm would write all-zeros, the cell receives its original word v. Where it would write all-ones, the cell receives the complement of v. Each cell is complemented four times in total, so the final write puts v back.

The same operation sequence runs twice. In the first pass, the predict pass, every write is suppressed. Each read word is XORed with the background the algorithm expects at that point, which gives the response a fault-free RAM will return in the second pass. These predicted responses are compressed into a 16-bit multiple-input signature register. In the second pass, the test pass, the real reads and writes are performed. The raw read words are compressed into the cleared register, and the result is compared with the stored prediction.

The block needs no storage for the original contents. Each write takes the complement of the word read from the same address one cycle earlier. The RAM is driven directly through address, write data, write enable and read data. A single start pulse runs the whole test. Done then rises and stays high with the fail verdict until the next start.

Top module: `tmarch_bist`

## Requirements
- R1: After reset, done, fail and ram_we are 0, and the block issues no write until start is seen.
- R2: Start is accepted on a rising clock edge only while no test is running, that is after reset or once done is high. A start pulse during a running test has no effect on its operation sequence or on its length.
- R3: One RAM operation is issued per clock. The read word is taken from ram_rdata in the same cycle the address is driven, so the RAM read must be combinational. Each pass walks six elements indexed 0 to 5 over the 16 addresses. Element 0 reads ascending. Elements 1 and 2 read then write each address, ascending. Elements 3 and 4 do the same descending, from address 15 down to 0. Element 5 reads ascending. A write always uses the address of the read just before it. Each pass lasts 160 cycles.
- R4: During the predict pass (the first 160 cycles after start is accepted) ram_we stays 0.
- R5: During the test pass, every write stores the bitwise complement of the word read from the same address in the preceding cycle. A test pass issues exactly 64 writes.
- R6: On a fault-free RAM, every word after the test equals its value before the test.
- R7: The signature register is 16 bits wide. Each step shifts right by one, XORs in the mask 0xB400 when the bit shifted out was 1, then XORs the response word into bits 7:0. The register is cleared at the start of each pass. In the predict pass the response is the read word XORed with 0xFF in elements 2 and 4 and unchanged elsewhere. In the test pass the response is the raw read word.
- R8: Done rises 320 clock edges after the edge that accepted start, and holds until the next accepted start. Fail is only high while done is high. Fail is 1 exactly when the two signatures differ: it is 0 on a fault-free RAM and 1 when any one data bit of the RAM is stuck at 0 or at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test; ignored while a test runs |
| ram_addr | output | 4 | RAM word address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable, one word per clock |
| ram_rdata | input | 8 | RAM read data, combinational from ram_addr |
| done | output | 1 | Test complete; held until next start |
| fail | output | 1 | Signature mismatch verdict, valid with done |

## Verification
The hardest situation to reach from the ports is a RAM that returns the correct word during the predict pass yet misbehaves in the test pass. A bit stuck at the value the cell already holds does exactly this: the predict pass sees nothing wrong, and only a complementing write exposes the fault. The bench's RAM model forces chosen bits of chosen cells on the read path. It sweeps every bit of the first and last cell at both stuck values, over backgrounds whose bits sometimes match the stuck value and sometimes do not. Fault-free runs over several backgrounds check the complete address, write-enable and write-data trace cycle by cycle, and then check that the contents are restored. One run also pulses start in the middle of the test.

// File: rtl/tmarch_pkg.sv
package tmarch_pkg;

  localparam int SIG_W  = 16;
  localparam int N_ELEM = 6;
  localparam int ELEM_W = 3;

  typedef logic [SIG_W-1:0]  sig_t;
  typedef logic [ELEM_W-1:0] elem_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  // elements 1..4 are read-then-write pairs
  function automatic logic elem_has_write(elem_t e);
    return (e >= elem_t'(1)) && (e <= elem_t'(4));
  endfunction

  // elements 3 and 4 walk addresses downward
  function automatic logic elem_descending(elem_t e);
    return (e == elem_t'(3)) || (e == elem_t'(4));
  endfunction

  // expected background relative to the original word: 1 means inverted
  function automatic logic elem_read_inverted(elem_t e);
    return (e == elem_t'(2)) || (e == elem_t'(4));
  endfunction

  // one Galois right-shift step, response folded in afterwards
  function automatic sig_t misr_step(sig_t s, sig_t d, sig_t poly);
    sig_t t;
    t = s >> 1;
    if (s[0]) t = t ^ poly;
    return t ^ d;
  endfunction

endpackage

// File: rtl/tmarch_seq.sv
module tmarch_seq
  import tmarch_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              go,
  output logic              pass,
  output logic              rd_slot,
  output logic              wr_slot,
  output logic              pass0_end,
  output logic              pass1_end,
  output elem_t             elem,
  output logic [ADDR_W-1:0] addr
);

  localparam elem_t LAST_ELEM = elem_t'(N_ELEM - 1);

  st_e               state_q;
  logic              pass_q;
  elem_t             elem_q;
  logic [ADDR_W-1:0] idx_q;
  logic              op_q;

  logic run;
  logic last_op;
  logic last_idx;
  logic pass_last;

  assign run       = (state_q == ST_RUN);
  assign go        = start && !run;
  assign last_op   = op_q || !elem_has_write(elem_q);
  assign last_idx  = (idx_q == {ADDR_W{1'b1}});
  assign pass_last = run && last_op && last_idx && (elem_q == LAST_ELEM);

  assign pass      = pass_q;
  assign elem      = elem_q;
  assign rd_slot   = run && !op_q;
  assign wr_slot   = run && op_q;
  assign pass0_end = pass_last && !pass_q;
  assign pass1_end = pass_last && pass_q;
  assign addr      = elem_descending(elem_q) ? ~idx_q : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      elem_q  <= '0;
      idx_q   <= '0;
      op_q    <= 1'b0;
    end else if (go) begin
      state_q <= ST_RUN;
      pass_q  <= 1'b0;
      elem_q  <= '0;
      idx_q   <= '0;
      op_q    <= 1'b0;
    end else if (run) begin
      if (!last_op) begin
        op_q <= 1'b1;
      end else begin
        op_q <= 1'b0;
        if (last_idx) begin
          idx_q <= '0;
          if (elem_q == LAST_ELEM) begin
            elem_q <= '0;
            if (pass_q) state_q <= ST_DONE;
            else        pass_q  <= 1'b1;
          end else begin
            elem_q <= elem_q + elem_t'(1);
          end
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R3: a write slot is never followed directly by another write slot
  a_r3_no_double_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |=> !wr_slot);

  // R3: every write slot comes straight after a read slot at the same address
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |-> ($past(rd_slot) && addr == $past(addr)));

  // R3: the predict pass hands over to the test pass with no idle cycle
  a_r3_pass_handover: assert property (@(posedge clk) disable iff (!rst_n)
    pass0_end |=> (rd_slot && pass && elem == '0));

endmodule

// File: rtl/tmarch_misr.sv
module tmarch_misr
  import tmarch_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter sig_t POLY   = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output sig_t              sig_nxt
);

  localparam int PAD_W = SIG_W - DATA_W;

  sig_t sig_q;
  sig_t din_ext;

  assign din_ext = {{PAD_W{1'b0}}, din};
  assign sig_nxt = en ? misr_step(sig_q, din_ext, POLY) : sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sig_q <= '0;
    else if (clr) sig_q <= '0;
    else          sig_q <= sig_nxt;
  end

  // R7: a clear leaves the register empty for the first response of a pass
  a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == '0));

  // R7: without a response the register holds
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(sig_q));

endmodule

// File: rtl/tmarch_bist.sv
module tmarch_bist
  import tmarch_pkg::*;
#(
  parameter int   ADDR_W = 4,
  parameter int   DATA_W = 8,
  parameter sig_t POLY   = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              done,
  output logic              fail
);

  logic              go;
  logic              pass;
  logic              rd_slot;
  logic              wr_slot;
  logic              pass0_end;
  logic              pass1_end;
  elem_t             elem;
  logic [DATA_W-1:0] rd_hold_q;
  logic [DATA_W-1:0] resp;
  logic              predict_inv;
  sig_t              sig_nxt;
  sig_t              pred_q;
  logic              done_q;
  logic              fail_q;

  tmarch_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .go        (go),
    .pass      (pass),
    .rd_slot   (rd_slot),
    .wr_slot   (wr_slot),
    .pass0_end (pass0_end),
    .pass1_end (pass1_end),
    .elem      (elem),
    .addr      (ram_addr)
  );

  // predict pass: model the fault-free response from the untouched word
  assign predict_inv = !pass && elem_read_inverted(elem);
  assign resp        = predict_inv ? ~ram_rdata : ram_rdata;

  tmarch_misr #(.DATA_W(DATA_W), .POLY(POLY)) u_misr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (go || pass0_end),
    .en      (rd_slot),
    .din     (resp),
    .sig_nxt (sig_nxt)
  );

  // every write in the transparent algorithm complements the cell
  assign ram_we    = wr_slot && pass;
  assign ram_wdata = ~rd_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold_q <= '0;
      pred_q    <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      if (rd_slot) rd_hold_q <= ram_rdata;
      if (pass0_end) pred_q <= sig_nxt;
      if (go) begin
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (pass1_end) begin
        done_q <= 1'b1;
        fail_q <= (sig_nxt != pred_q);
      end
    end
  end

  assign done = done_q;
  assign fail = fail_q;

  // R5: the stored word is the complement of what the port returned a cycle earlier
  a_r5_write_complements: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wdata == ~$past(ram_rdata)));

  // R5: a write reuses the address of the preceding read
  a_r5_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == $past(ram_addr)));

  // R8: the verdict is only shown together with done
  a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  // R8: done holds until a new start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail)));

  // R1/R4: no write while done is shown
  a_r4_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ram_we);

endmodule

// File: tb/test_tmarch_bist.sv
`timescale 1ns/100ps
module test_tmarch_bist;

  localparam int N_WORDS = 16;
  localparam int N_OPS   = 320;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       ram_we;
  logic [7:0] ram_rdata;
  logic       done;
  logic       fail;

  logic [7:0] mem   [N_WORDS];
  logic [7:0] saved [N_WORDS];
  int         exp_addr [N_OPS];
  bit         exp_we   [N_OPS];

  bit         flt_en  = 1'b0;
  int         flt_adr = 0;
  int         flt_bit = 0;
  logic       flt_val = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  tmarch_bist i_tmarch_bist (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .ram_rdata (ram_rdata),
    .done      (done),
    .fail      (fail)
  );

  // RAM model: combinational read with an optional stuck bit
  always_comb begin
    logic [7:0] t;
    t = mem[ram_addr];
    if (flt_en && int'(ram_addr) == flt_adr) t[flt_bit] = flt_val;
    ram_rdata = t;
  end

  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", cyc, 150000);
        report();
        $finish;
      end
    end
  end

  // expected operation trace, built from the element list of R3/R4
  initial begin
    int n;
    n = 0;
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 6; e++)
        for (int i = 0; i < N_WORDS; i++) begin
          int a;
          a = (e == 3 || e == 4) ? (N_WORDS - 1 - i) : i;
          exp_addr[n] = a; exp_we[n] = 1'b0; n++;
          if (e >= 1 && e <= 4) begin
            exp_addr[n] = a; exp_we[n] = (p == 1); n++;
          end
        end
  end

  task automatic fill(input int kind, input int seed);
    for (int a = 0; a < N_WORDS; a++) begin
      case (kind)
        0: mem[a] = 8'h00;
        1: mem[a] = 8'hFF;
        2: mem[a] = (a % 2 == 0) ? 8'h55 : 8'hAA;
        3: mem[a] = 8'(a * 17);
        default: mem[a] = 8'((a * 37 + seed * 11) ^ (seed << 3) ^ (a << 5));
      endcase
      saved[a] = mem[a];
    end
  endtask

  task automatic run_bist(input int inj, input bit exp_fail);
    int k, wr0, wr1;
    start = 1'b1;
    @(negedge clk);
    k = 0; wr0 = 0; wr1 = 0;
    while (!done && k < 400) begin
      start = (k == inj);
      if (k < N_OPS) begin
        bit ok;
        ok = (int'(ram_addr) == exp_addr[k]) && (ram_we == exp_we[k]);
        if (ram_we && !flt_en) ok = ok && (ram_wdata == ~mem[ram_addr]);
        if (k < 160)
          chk(ok, "R4", "predict-pass trace addr/we", {ram_we, ram_addr}, {exp_we[k], exp_addr[k][3:0]});
        else
          chk(ok, "R5", "test-pass trace addr/we/wdata", {ram_we, ram_addr, ram_wdata},
              {exp_we[k], exp_addr[k][3:0], ~mem[exp_addr[k]]});
      end
      if (ram_we) begin
        if (k < 160) wr0++; else wr1++;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == N_OPS, "R8", "cycles to done", k, N_OPS);
    chk(wr0 == 0, "R4", "writes in predict pass", wr0, 0);
    chk(wr1 == 64, "R5", "writes in test pass", wr1, 64);
    chk(fail == exp_fail, "R8", "fail verdict", fail, exp_fail);
    if (!flt_en)
      for (int a = 0; a < N_WORDS; a++)
        chk(mem[a] == saved[a], "R6", "restored word", mem[a], saved[a]);
    repeat (3) @(negedge clk);
    chk(done && !ram_we && fail == exp_fail, "R8", "done/fail hold", {done, ram_we, fail}, {1'b1, 1'b0, exp_fail});
  endtask

  initial begin
    fill(0, 0);
    repeat (3) @(negedge clk);
    chk(!done && !fail && !ram_we, "R1", "reset outputs", {done, fail, ram_we}, 0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(!done && !fail && !ram_we, "R1", "idle without start", {done, fail, ram_we}, 0);
    end

    // fault-free sweep over backgrounds (R3..R8, R7 via matching signatures)
    for (int kind = 0; kind < 5; kind++) begin
      fill(kind, 0);
      run_bist(-1, 1'b0);
    end
    for (int s = 1; s < 5; s++) begin
      fill(4, s);
      run_bist(-1, 1'b0);
    end

    // R2: a start pulse in the middle of a test changes nothing
    fill(4, 9);
    run_bist(100, 1'b0);

    // R8: stuck bits in first and last cell, both values, two backgrounds
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 8; b++)
        for (int v = 0; v < 2; v++) begin
          fill((b % 2 == 0) ? 2 : 4, b + v);
          flt_en = 1'b1; flt_adr = (c == 0) ? 0 : N_WORDS - 1;
          flt_bit = b; flt_val = v[0];
          run_bist(-1, 1'b1);
          flt_en = 1'b0;
        end

    // R2: restart after a faulty run clears the verdict
    fill(3, 0);
    run_bist(-1, 1'b0);

    report();
    $finish;
  end

endmodule